// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns characters written into a one-entry transmit buffer into asynchronous serial frames on a single output line. Bit timing comes from an external baud-rate generator, which supplies a one-clock pulse once per bit period. Every frame bit begins on one of these pulses and lasts until the next. A frame is a start bit, then 5 to 8 data bits, then an optional odd or even parity bit, then one or two stop bits. Output polarity and data bit order are also set by configuration inputs.

The holding buffer is separate from the shift register. Software can therefore load the next character while the current one is still going out, and consecutive frames leave no idle time between them. A status output shows whether the buffer still holds an unsent character. A one-cycle interrupt pulse marks each move from the buffer into the shift register, which is the moment the buffer can take another character. The block is held in reset while both of its disable inputs are high.

Top module: `uart_frame_tx`

## Requirements
- R1: While `rst` is high, or while `dis_a` and `dis_b` are both high, the buffer is empty, `shifting` is low, `txd` sits at the idle level, and writes are ignored.
- R2: `cfg_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Only that many low bits of `wr_data` are sent, and the higher bits have no effect.
- R3: When `cfg_par_en` is 1, a parity bit follows the last data bit. With `cfg_par_odd` 0 the parity is even, so the data bits plus the parity bit hold an even number of ones. With `cfg_par_odd` 1 the parity is odd. When `cfg_par_en` is 0, no parity bit is sent.
- R4: After the data bits and any parity bit, one stop bit is sent when `cfg_two_stop` is 0 and two when it is 1. Stop bits are at the high level in positive logic.
- R5: In positive logic the line idles high and each frame opens with a low start bit. A frame starts on the first `bit_tick` after the buffer fills while the line is idle, and each frame bit lasts exactly one tick period.
- R6: With `cfg_msb_first` 0, data goes out from bit 0 upward. With `cfg_msb_first` 1, data goes out from bit (length-1) downward.
- R7: With `cfg_invert` 1, every level on `txd` is inverted, including the idle level, the start bit and the stop bits.
- R8: An accepted write sets `buf_full`. `buf_full` clears when the character moves into the shift register. `shifting` is high from the start bit through the last stop bit.
- R9: If the buffer is full when the last stop bit ends, the next start bit follows at once, with no idle period.
- R10: A write while `buf_full` is high is ignored and leaves the buffered character unchanged.
- R11: `tx_irq` pulses high for one clock each time the buffer contents move into the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dis_a | input | 1 | Disable bit A; both disable bits high hold the block in reset |
| dis_b | input | 1 | Disable bit B |
| bit_tick | input | 1 | One-clock pulse per bit period from the baud generator |
| cfg_len | input | 2 | Data length code (5 + code bits) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_invert | input | 1 | 1 inverts the whole line (negative logic) |
| cfg_msb_first | input | 1 | 1 sends the highest data bit first |
| wr_en | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial output line |
| buf_full | output | 1 | Buffer holds an unsent character |
| shifting | output | 1 | A frame is being sent |
| tx_irq | output | 1 | Pulse when the buffer is emptied into the shift register |

## Verification
Frames are sent with characters whose bit patterns are asymmetric, so that a reversed order, a shifted index or a wrong length each shows up as a distinct bit error. The data length, parity mode, stop count, polarity and bit order are changed between frames. One character has ones above the configured length, which exposes any failure to mask it. Back-to-back writes separate a correct zero-gap handoff from a design that inserts an idle bit or loses the queued character. A write to a full buffer with a third, different value shows whether the buffered character is overwritten or a third frame is sent. Asserting both disable bits in the middle of a frame shows whether the line returns to idle and whether the block then stays quiet.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_START,
    FR_DATA,
    FR_PAR,
    FR_STOP
  } fr_state_t;

  typedef struct packed {
    logic [1:0] len_code;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
    logic       msb_first;
  } fr_cfg_t;

  localparam int unsigned LEN_BASE = 5;

endpackage

// File: rtl/uftx_holdbuf.sv
module uftx_holdbuf #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data_q
);

  always_ff @(posedge clk) begin
    if (clr) begin
      full   <= 1'b0;
      data_q <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (wr_en && !full) begin
      full   <= 1'b1;
      data_q <= wr_data;
    end
  end

endmodule

// File: rtl/uftx_framer.sv
module uftx_framer
  import uftx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          tick,
  input  fr_cfg_t       cfg,
  input  logic          buf_full,
  input  logic [DW-1:0] buf_data,
  output logic          take,
  output logic          line,
  output logic          busy
);

  localparam int unsigned CNT_W = $clog2(DW);
  localparam int unsigned NB_W  = $clog2(DW + 1);

  fr_state_t        st_q;
  logic [DW-1:0]    sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NB_W-1:0]  nbits_q;
  logic             msb_q, par_en_q, two_q, par_q, second_q;
  logic [NB_W-1:0]  nbits_new;
  logic [DW-1:0]    mask_new;
  logic             last_stop, last_data;

  function automatic logic [DW-1:0] mask_for(input logic [NB_W-1:0] nb);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = (NB_W'(i) < nb);
    return m;
  endfunction

  function automatic logic bit_at(input logic [DW-1:0] sh, input logic msb,
                                  input logic [NB_W-1:0] nb,
                                  input logic [CNT_W-1:0] k);
    logic [NB_W-1:0] t;
    t = msb ? (nb - NB_W'(1) - NB_W'(k)) : NB_W'(k);
    return sh[t[CNT_W-1:0]];
  endfunction

  assign nbits_new = NB_W'(cfg.len_code) + NB_W'(LEN_BASE);
  assign mask_new  = mask_for(nbits_new);
  assign last_stop = !(two_q && !second_q);
  assign last_data = (NB_W'(cnt_q) == nbits_q - NB_W'(1));
  assign take      = tick && buf_full &&
                     ((st_q == FR_IDLE) || ((st_q == FR_STOP) && last_stop));
  assign busy      = (st_q != FR_IDLE);

  always_ff @(posedge clk) begin
    if (clr) begin
      st_q     <= FR_IDLE;
      line     <= 1'b1;
      sh_q     <= '0;
      cnt_q    <= '0;
      nbits_q  <= NB_W'(DW);
      msb_q    <= 1'b0;
      par_en_q <= 1'b0;
      two_q    <= 1'b0;
      par_q    <= 1'b0;
      second_q <= 1'b0;
    end else if (take) begin
      st_q     <= FR_START;
      line     <= 1'b0;
      sh_q     <= buf_data & mask_new;
      nbits_q  <= nbits_new;
      msb_q    <= cfg.msb_first;
      par_en_q <= cfg.par_en;
      two_q    <= cfg.two_stop;
      par_q    <= (^(buf_data & mask_new)) ^ cfg.par_odd;
      cnt_q    <= '0;
    end else if (tick) begin
      case (st_q)
        FR_START: begin
          st_q  <= FR_DATA;
          cnt_q <= '0;
          line  <= bit_at(sh_q, msb_q, nbits_q, '0);
        end
        FR_DATA: begin
          if (last_data) begin
            second_q <= 1'b0;
            if (par_en_q) begin
              st_q <= FR_PAR;
              line <= par_q;
            end else begin
              st_q <= FR_STOP;
              line <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
            line  <= bit_at(sh_q, msb_q, nbits_q, cnt_q + 1'b1);
          end
        end
        FR_PAR: begin
          st_q     <= FR_STOP;
          line     <= 1'b1;
          second_q <= 1'b0;
        end
        FR_STOP: begin
          if (!last_stop) begin
            second_q <= 1'b1;
          end else begin
            st_q <= FR_IDLE;
            line <= 1'b1;
          end
        end
        default: begin
          st_q <= FR_IDLE;
          line <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/uftx_lineout.sv
module uftx_lineout (
  input  logic clk,
  input  logic clr,
  input  logic line,
  input  logic invert,
  input  logic take,
  output logic txd,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (clr) begin
      txd <= ~invert;
      irq <= 1'b0;
    end else begin
      txd <= line ^ invert;
      irq <= take;
    end
  end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uftx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dis_a,
  input  logic          dis_b,
  input  logic          bit_tick,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_two_stop,
  input  logic          cfg_invert,
  input  logic          cfg_msb_first,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          txd,
  output logic          buf_full,
  output logic          shifting,
  output logic          tx_irq
);

  logic          clr;
  logic          take;
  logic          line;
  logic [DW-1:0] buf_word;
  fr_cfg_t       cfg;

  assign clr = rst | (dis_a & dis_b);
  assign cfg = '{len_code: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd,
                 two_stop: cfg_two_stop, msb_first: cfg_msb_first};

  uftx_holdbuf #(.DW(DW)) u_buf (
    .clk(clk), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
    .take(take), .full(buf_full), .data_q(buf_word)
  );

  uftx_framer #(.DW(DW)) u_framer (
    .clk(clk), .clr(clr), .tick(bit_tick), .cfg(cfg),
    .buf_full(buf_full), .buf_data(buf_word),
    .take(take), .line(line), .busy(shifting)
  );

  uftx_lineout u_out (
    .clk(clk), .clr(clr), .line(line), .invert(cfg_invert),
    .take(take), .txd(txd), .irq(tx_irq)
  );

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          dis_a,
  input logic          dis_b,
  input logic          bit_tick,
  input logic          wr_en,
  input logic          cfg_invert,
  input logic          txd,
  input logic          buf_full,
  input logic          shifting,
  input logic          tx_irq,
  input logic [DW-1:0] buf_word
);

  // R1
  held_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(dis_a && dis_b) |-> (!buf_full && !shifting && !tx_irq &&
                               (txd == !$past(cfg_invert))));

  // R11
  irq_on_transfer_chk: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> (!buf_full && $past(buf_full)));

  // R8
  fill_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_full) |-> $past(wr_en));

  // R5
  start_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(shifting) |-> ($past(bit_tick) && tx_irq));

  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!shifting && $past(!shifting)) |-> (txd == !$past(cfg_invert)));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (buf_full && $past(buf_full)) |-> $stable(buf_word));

endmodule

bind uart_frame_tx uart_frame_tx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .dis_a(dis_a), .dis_b(dis_b), .bit_tick(bit_tick),
  .wr_en(wr_en), .cfg_invert(cfg_invert), .txd(txd), .buf_full(buf_full),
  .shifting(shifting), .tx_irq(tx_irq), .buf_word(buf_word)
);

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dis_a = 1'b0, dis_b = 1'b0, bit_tick = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic       cfg_invert = 1'b0, cfg_msb_first = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       txd, buf_full, shifting, tx_irq;

  int checks = 0, errors = 0, irq_cnt = 0;
  logic [63:0] exp_v;
  int exp_n;
  bit done = 0;

  always #10 clk = ~clk;

  uart_frame_tx u_uart_frame_tx (
    .clk(clk), .rst(rst), .dis_a(dis_a), .dis_b(dis_b), .bit_tick(bit_tick),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_invert(cfg_invert),
    .cfg_msb_first(cfg_msb_first), .wr_en(wr_en), .wr_data(wr_data),
    .txd(txd), .buf_full(buf_full), .shifting(shifting), .tx_irq(tx_irq)
  );

  // bit tick every 8 clocks
  initial begin
    forever begin
      repeat (7) @(negedge clk);
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (tx_irq) irq_cnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int lc, input bit pe, input bit po, input bit ts,
                         input bit mf, input bit inv);
    @(negedge clk);
    cfg_len = 2'(lc); cfg_par_en = pe; cfg_par_odd = po;
    cfg_two_stop = ts; cfg_msb_first = mf; cfg_invert = inv;
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic add_frame(input logic [7:0] d);
    int len;
    bit p;
    len = int'(cfg_len) + 5;
    exp_v[exp_n] = 1'b0; exp_n = exp_n + 1;
    for (int i = 0; i < len; i++) begin
      exp_v[exp_n] = d[cfg_msb_first ? (len - 1 - i) : i];
      exp_n = exp_n + 1;
    end
    if (cfg_par_en) begin
      p = 1'b0;
      for (int j = 0; j < len; j++) p = p ^ d[j];
      exp_v[exp_n] = p ^ cfg_par_odd; exp_n = exp_n + 1;
    end
    exp_v[exp_n] = 1'b1; exp_n = exp_n + 1;
    if (cfg_two_stop) begin
      exp_v[exp_n] = 1'b1; exp_n = exp_n + 1;
    end
  endtask

  // waits for a start bit, then samples each expected bit at its centre
  task automatic run_frames(input string req, input int idle_after);
    int w;
    w = 0;
    while (txd !== cfg_invert && w < 400) begin
      @(negedge clk);
      w++;
    end
    check(w < 400, {req, " start bit"}, int'(txd), int'(cfg_invert));
    repeat (4) @(negedge clk);
    for (int i = 0; i < exp_n; i++) begin
      check(txd === (exp_v[i] ^ cfg_invert), $sformatf("%s bit %0d", req, i),
            int'(txd), int'(exp_v[i] ^ cfg_invert));
      repeat (8) @(negedge clk);
    end
    for (int k = 0; k < idle_after; k++) begin
      check(txd === ~cfg_invert && !shifting, {req, " idle after frame"},
            int'(txd), int'(~cfg_invert));
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check(txd === 1'b1, "R1 reset txd", int'(txd), 1);
    check(buf_full === 1'b0 && shifting === 1'b0 && tx_irq === 1'b0,
          "R1 reset flags", int'({buf_full, shifting, tx_irq}), 0);
  endtask

  task automatic t_basic_8n1();
    int c0;
    set_cfg(3, 0, 0, 0, 0, 0);
    exp_n = 0; add_frame(8'hA5);
    c0 = irq_cnt;
    write(8'hA5);
    check(buf_full === 1'b1, "R8 buffer flag after write", int'(buf_full), 1);
    run_frames("R5 8N1 lsb", 1);
    check(irq_cnt == c0 + 1, "R11 one irq per frame", irq_cnt - c0, 1);
  endtask

  task automatic t_len7_even_2stop();
    set_cfg(2, 1, 0, 1, 0, 0);
    exp_n = 0; add_frame(8'hFF & 8'h7F);
    write(8'hFF);
    run_frames("R2 R3 R4 7E2 masked high bit", 1);
  endtask

  task automatic t_len5_odd_msb();
    set_cfg(0, 1, 1, 0, 1, 0);
    exp_n = 0; add_frame(8'hF3 & 8'h1F);
    write(8'hF3);
    run_frames("R6 R3 5O1 msb first", 1);
  endtask

  task automatic t_inverted();
    set_cfg(1, 1, 1, 1, 0, 1);
    repeat (3) @(negedge clk);
    check(txd === 1'b0, "R7 inverted idle level", int'(txd), 0);
    exp_n = 0; add_frame(8'h2C);
    write(8'h2C);
    run_frames("R7 inverted 6O2", 1);
    set_cfg(3, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_back_to_back();
    int c0;
    set_cfg(3, 1, 0, 0, 1, 0);
    exp_n = 0; add_frame(8'h3C); add_frame(8'hC1);
    c0 = irq_cnt;
    fork
      run_frames("R9 back to back", 1);
      begin
        write(8'h3C);
        while (buf_full) @(negedge clk);
        check(shifting === 1'b1, "R8 shifting after transfer", int'(shifting), 1);
        write(8'hC1);
        check(buf_full === 1'b1, "R8 buffered during shift", int'(buf_full), 1);
      end
    join
    check(irq_cnt == c0 + 2, "R11 irq per transfer", irq_cnt - c0, 2);
  endtask

  task automatic t_full_ignored();
    set_cfg(3, 0, 0, 0, 0, 0);
    exp_n = 0; add_frame(8'h81); add_frame(8'h6E);
    fork
      run_frames("R10 write while full", 2);
      begin
        write(8'h81);
        while (buf_full) @(negedge clk);
        write(8'h6E);
        write(8'h55);
        check(buf_full === 1'b1, "R10 still full after ignored write", int'(buf_full), 1);
      end
    join
  endtask

  task automatic t_disable();
    int w;
    set_cfg(3, 0, 0, 0, 0, 0);
    write(8'h00);
    w = 0;
    while (txd !== 1'b0 && w < 400) begin
      @(negedge clk);
      w++;
    end
    repeat (12) @(negedge clk);
    dis_a = 1'b1;
    repeat (2) @(negedge clk);
    check(shifting === 1'b1, "R1 one disable bit alone", int'(shifting), 1);
    dis_b = 1'b1;
    repeat (2) @(negedge clk);
    check(txd === 1'b1 && !shifting && !buf_full, "R1 disabled mid frame",
          int'({txd, shifting, buf_full}), 4);
    write(8'h12);
    check(buf_full === 1'b0, "R1 write ignored while disabled", int'(buf_full), 0);
    dis_a = 1'b0; dis_b = 1'b0;
    for (int k = 0; k < 4; k++) begin
      repeat (10) @(negedge clk);
      check(txd === 1'b1 && !shifting, "R1 quiet after release", int'(txd), 1);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic_8n1();
    t_len7_even_2stop();
    t_len5_odd_msb();
    t_inverted();
    t_back_to_back();
    t_full_ignored();
    t_disable();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule